// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit down-counting timer channel with six operating behaviours: a one-shot that raises its output at terminal count, a gate-retriggered one-shot, a rate generator, a square-wave generator, and software- and gate-triggered strobes. The count runs in binary or as four decimal digits. A surrounding register interface writes the control word and the initial count through a one-cycle load strobe. It samples the live count and the output level whenever it needs them.

Counting advances only on clocks where `cnt_en` is high. `cnt_en` is the divided counter clock expressed as an enable. In the level-gated behaviours, the gate input pauses and resumes counting. In the others, a rising gate edge restarts the period from the initial count. The operating behaviour and the number base are captured together with the initial count at the load strobe.

Top module: `interval_counter`

## Requirements
- R1: Out of reset, `count` is 0 and `out` is low. Neither changes, whatever `cnt_en` and `gate` do, until the first load strobe.
- R2: A loaded value of 0 stands for the largest period: 65536 counts in binary, 10000 counts in BCD.
- R3: In modes 0, 1, 4 and 5 the counter keeps decrementing past zero. It wraps to 16'hFFFF in binary and to 16'h9999 in BCD.
- R4: With `bcd` = 1 at load, `count` holds four decimal digits, least significant digit in bits 3:0. Each decrement borrows digit by digit.
- R5: In mode 0, `out` is low from the load. It rises on the enable after which N counts have elapsed and stays high until the next load.
- R6: In mode 1, `out` is high from the load or retrigger. It drops once N counts have elapsed.
- R7: In mode 2 the count runs N down to 1 and then reloads N. `out` is high for exactly one count at each whole multiple of N elapsed counts, and is not high at the load itself.
- R8: In mode 3 each enable lowers the count by two modulo N. `out` is high for the first (N+1)/2 counts of every N-count period and low for the rest. With N = 1, `out` stays high.
- R9: In modes 4 and 5, `out` is high only while exactly N counts have elapsed since the load or trigger. It is not high again after a wrap.
- R10: In modes 0 and 4, counting happens only while `gate` is high. Gate edges do not restart.
- R11: In modes 1, 2, 3 and 5, a rising `gate` edge restarts the count at N with zero elapsed counts. The gate level otherwise has no effect.
- R12: `mode` values 6 and 7 act as modes 2 and 3. `mode` and `bcd` take effect only at a load strobe.
- R13: A load strobe takes priority over a same-cycle enable or gate edge. `count` shows the loaded value on the next cycle, and counting starts on the following enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter clock enable, one count per high cycle |
| gate | input | 1 | Gate: level enable or rising-edge trigger, by mode |
| load | input | 1 | One-cycle strobe capturing `load_val`, `mode`, `bcd` |
| load_val | input | 16 | Initial count N (0 = maximum) |
| mode | input | 3 | Operating behaviour 0..7 |
| bcd | input | 1 | 1 = four-digit decimal counting |
| count | output | 16 | Current count |
| out | output | 1 | Channel output waveform |

## Verification
The embedded properties assume that `load_val` holds four valid decimal digits whenever it is loaded with `bcd` high. The digit-range check depends on this. They also assume that every input is stable across the active clock edge. The stimulus changes inputs only on the falling edge and writes only valid digit patterns in decimal tests. A reference model in the bench keeps an elapsed-count integer per load or trigger and derives the expected count and output from it arithmetically. It is compared on every cycle, including long runs across the binary and decimal maximum periods.

// File: rtl/interval_counter.sv
module interval_counter #(
  parameter int DIGITS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cnt_en,
  input  logic                  gate,
  input  logic                  load,
  input  logic [4*DIGITS-1:0]   load_val,
  input  logic [2:0]            mode,
  input  logic                  bcd,
  output logic [4*DIGITS-1:0]   count,
  output logic                  out
);
  localparam int W = 4 * DIGITS;

  logic         gate_q, armed, bcd_q, out_q, done;
  logic [2:0]   mode_q;
  logic [W-1:0] n_q, cur;

  function automatic logic [W-1:0] dec(input logic [W-1:0] v, input logic b);
    logic [W-1:0] r;
    logic borrow;
    r = v - 1'b1;
    if (b) begin
      r = v;
      borrow = 1'b1;
      for (int i = 0; i < DIGITS; i++) begin
        if (borrow) begin
          if (v[4*i +: 4] == 4'd0) r[4*i +: 4] = 4'd9;
          else begin
            r[4*i +: 4] = v[4*i +: 4] - 4'd1;
            borrow = 1'b0;
          end
        end
      end
    end
    return r;
  endfunction

  wire [2:0]   m_in    = (mode[2:1] == 2'b11) ? {1'b0, mode[1:0]} : mode;
  wire         gated   = (mode_q == 3'd0) || (mode_q == 3'd4);
  wire         restart = armed & ~load & ~gated & gate & ~gate_q;
  wire         tick    = armed & ~load & ~restart & cnt_en & (~gated | gate);
  wire         one     = (cur == W'(1));
  wire         two     = (cur == W'(2));
  wire [W-1:0] nxt1    = dec(cur, bcd_q);
  wire [W-1:0] nxt2    = dec(nxt1, bcd_q);
  wire [W-1:0] nm1     = dec(n_q, bcd_q);

  assign count = cur;
  assign out   = out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      armed  <= 1'b0;
      mode_q <= 3'd0;
      bcd_q  <= 1'b0;
      n_q    <= '0;
      cur    <= '0;
      out_q  <= 1'b0;
      done   <= 1'b0;
    end else begin
      gate_q <= gate;
      if (load) begin
        armed  <= 1'b1;
        mode_q <= m_in;
        bcd_q  <= bcd;
        n_q    <= load_val;
        cur    <= load_val;
        done   <= 1'b0;
        out_q  <= (m_in == 3'd1) || (m_in == 3'd3);
      end else if (restart) begin
        cur   <= n_q;
        done  <= 1'b0;
        out_q <= (mode_q == 3'd1) || (mode_q == 3'd3);
      end else if (tick) begin
        case (mode_q)
          3'd2: begin
            cur   <= one ? n_q : nxt1;
            out_q <= one;
          end
          3'd3: begin
            if (n_q != W'(1)) begin
              if (one) begin
                cur   <= nm1;
                out_q <= ~out_q;
              end else if (two) begin
                cur   <= n_q;
                out_q <= ~out_q;
              end else begin
                cur <= nxt2;
              end
            end
          end
          default: begin
            cur <= nxt1;
            if (one && !done) done <= 1'b1;
            case (mode_q)
              3'd0:    if (one && !done) out_q <= 1'b1;
              3'd1:    if (one && !done) out_q <= 1'b0;
              default: out_q <= one && !done;
            endcase
          end
        endcase
      end
    end
  end

  assert_idle_before_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!out && count == '0));

  assert_sticky_terminal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && mode_q == 3'd0 && out && !load) |=> out);

  assert_rate_quiet_at_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && m_in == 3'd2) |=> !out);

  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && out && (mode_q == 3'd4 || mode_q == 3'd5)) |=> !out);

  assert_gate_low_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && gated && !gate && !load) |=> $stable(count));

  assert_square_starts_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && m_in == 3'd3) |=> out);

  generate
    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
      assert_digit_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && bcd_q) |-> (cur[4*g +: 4] <= 4'd9));
    end
  endgenerate
endmodule

// File: tb/sim_interval_counter.sv
module sim_interval_counter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0, gate = 1'b0, load = 1'b0, bcd = 1'b0;
  logic [15:0] load_val = '0;
  logic [2:0]  mode = '0;
  logic [15:0] count;
  logic        out;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  int  m_mode = 0, nn = 1, d = 0;
  bit  m_arm = 0, m_bcd = 0, gprev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  interval_counter u0 (.clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .gate(gate),
    .load(load), .load_val(load_val), .mode(mode), .bcd(bcd), .count(count), .out(out));

  function automatic int from_bcd(input logic [15:0] v);
    return v[15:12]*1000 + v[11:8]*100 + v[7:4]*10 + v[3:0];
  endfunction

  function automatic logic [15:0] to_bcd(input int v);
    return {4'((v/1000)%10), 4'((v/100)%10), 4'((v/10)%10), 4'(v%10)};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_arm = 0;
      gprev = 0;
    end else begin
      bit rise;
      bit lvl;
      rise = gate && !gprev;
      gprev = gate;
      if (load) begin
        m_mode = (mode >= 6) ? int'(mode) - 4 : int'(mode);
        m_bcd  = bcd;
        nn     = bcd ? from_bcd(load_val) : int'(load_val);
        if (nn == 0) nn = bcd ? 10000 : 65536;
        d      = 0;
        m_arm  = 1;
      end else if (m_arm) begin
        lvl = (m_mode == 0 || m_mode == 4);
        if (!lvl && rise) d = 0;
        else if (cnt_en && (!lvl || gate)) d++;
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      int mm, v, ec, eo;
      mm = m_bcd ? 10000 : 65536;
      if (!m_arm) begin
        ec = 0; eo = 0;
      end else begin
        case (m_mode)
          2: begin v = (nn - d % nn) % mm; eo = (d % nn == 0) && (d != 0); end
          3: begin v = (nn - (2*d) % nn) % mm; eo = (d % nn) < (nn + 1) / 2; end
          default: begin
            v = ((nn - d) % mm + mm) % mm;
            case (m_mode)
              0: eo = (d >= nn);
              1: eo = (d < nn);
              default: eo = (d == nn);
            endcase
          end
        endcase
        ec = m_bcd ? int'(to_bcd(v)) : v;
      end
      check(cur_req, "count", int'(count), ec);
      check(cur_req, "out", int'(out), eo);
    end
  end

  task automatic ld(input logic [15:0] v, input logic [2:0] m, input logic b);
    @(negedge clk);
    load = 1; load_val = v; mode = m; bcd = b;
    @(negedge clk);
    load = 0;
  endtask

  task automatic run(input int n, input int pat);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cnt_en = (pat == 0) ? 1'b1 : (i % 3 != 0);
    end
  endtask

  task automatic pulse_gate();
    @(negedge clk); gate = 0;
    @(negedge clk); gate = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", "reset count", int'(count), 0);
    check("R1", "reset out", int'(out), 0);
    cur_req = "R1"; gate = 1; run(8, 0); gate = 0; run(4, 1);

    cur_req = "R5"; gate = 1; ld(16'd5, 3'd0, 0); run(12, 0);
    cur_req = "R3"; run(6, 1);
    cur_req = "R10"; ld(16'd6, 3'd0, 0); run(2, 0); gate = 0; run(5, 0);
    gate = 1; run(3, 0); pulse_gate(); run(6, 0);
    ld(16'd4, 3'd4, 0); gate = 0; run(3, 0); gate = 1; run(8, 0);

    cur_req = "R6"; ld(16'd4, 3'd1, 0); run(7, 0);
    cur_req = "R11"; pulse_gate(); run(2, 0); pulse_gate(); run(8, 1);

    cur_req = "R7"; ld(16'd3, 3'd2, 0); run(10, 0); ld(16'd1, 3'd2, 0); run(4, 0);
    ld(16'd4, 3'd2, 0); run(3, 0); cur_req = "R11"; pulse_gate(); run(9, 1);
    gate = 0; run(3, 0); gate = 1;

    cur_req = "R8"; ld(16'd5, 3'd3, 0); run(14, 0);
    ld(16'd4, 3'd3, 0); run(10, 1); ld(16'd1, 3'd3, 0); run(4, 0);
    ld(16'd2, 3'd3, 0); run(5, 0); ld(16'd7, 3'd3, 0); run(6, 0); pulse_gate(); run(9, 0);

    cur_req = "R12"; ld(16'd3, 3'd6, 0); run(8, 0); ld(16'd5, 3'd7, 0); run(8, 0);
    mode = 3'd0; bcd = 1; run(6, 0);

    cur_req = "R9"; ld(16'd3, 3'd4, 0); run(8, 0);
    ld(16'd3, 3'd5, 0); run(6, 0); pulse_gate(); run(6, 1);

    cur_req = "R13"; ld(16'd5, 3'd5, 0); run(2, 0);
    @(negedge clk); gate = 0;
    @(negedge clk); gate = 1; cnt_en = 1; load = 1; load_val = 16'd9; mode = 3'd2; bcd = 0;
    @(negedge clk); load = 0; run(12, 0);

    cur_req = "R4"; ld(16'h0012, 3'd0, 1); run(18, 0);
    cur_req = "R3"; run(5, 0);
    ld(16'h0100, 3'd2, 1); run(205, 1); ld(16'h0011, 3'd3, 1); run(25, 0);

    cur_req = "R2"; ld(16'h0000, 3'd4, 1); run(10005, 0);
    ld(16'h0000, 3'd0, 0); run(65540, 0);

    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule